// File: doc/BRIEF.md
# PCM Frame Timer

This block produces the bit-level frame timing for a programmable PCM/I2S style audio port. It runs entirely on the system clock. The bit clock is either generated here by a programmable divider or taken from an input pin through a synchronizer. Each selected edge of that bit clock becomes a one-cycle step strobe. A bit counter runs from zero up to a programmed frame length minus one and then wraps. The counter value and a frame-start flag go to the channel serializers, together with a pulse marking each new bit position.

When the block owns the frame sync, it drives a sync pulse whose length in bits is programmed separately from the frame length. A length of one gives a single-bit DSP-style pulse. Half the frame gives a 50% left/right clock. A polarity bit flips the pulse so that frames begin on a falling sync edge, as plain I2S expects. When another device owns the frame sync, the counter locks onto the chosen edge of the external sync input. It restarts on every such edge and wraps on its own if none arrives.

The bit clock source, its active edge and the clock disable act at once. The frame fields (length, sync length, sync source and sync polarity) are captured only when a new frame begins. No frame ever mixes two timings.

Top module: `pcm_frame_timer`

## Requirements
- R1: On each bit step the counter advances by one, from 0 to the 10-bit frame field value (frame length minus one, so up to 1024 bits), then returns to 0. `bitIndex` shows the counter.
- R2: When the frame sync is generated and `cfgFsInvert` is 0, `fsOut` is 1 while `bitIndex` < `cfgSyncLen` and 0 otherwise. It changes in the same cycle as `bitIndex`.
- R3: When the frame sync is generated and `cfgFsInvert` is 1, `fsOut` is the complement of the R2 level: 0 during the first `cfgSyncLen` bits of the frame.
- R4: With the internal bit clock, `bclkOut` toggles every `cfgHalfPeriod`+1 system cycles, so bit steps are 2·(`cfgHalfPeriod`+1) cycles apart. `bclkOut` stays 0 while `cfgBclkSlave` or `cfgClkDisable` is 1.
- R5: With `cfgBclkFallEdge` at 0, bit steps follow rising edges of the selected bit clock. With it at 1, they follow falling edges.
- R6: With `cfgBclkSlave` at 1, bit steps come from `bclkIn` after a two-stage synchronizer.
- R7: `frameStart` is 1 exactly while `bitIndex` is 0 in a running frame. `bitValid` is a one-cycle pulse in each cycle where `bitIndex` takes a new value.
- R8: With `cfgFsSlave` at 1, the counter stays idle (`bitIndex` 0, `frameStart` 0) until the first bit step at which the sampled `fsIn` shows a rising edge, or a falling edge when `cfgFsInvert` is 1. Every such edge sets the counter to 0. The sample history is 0 after reset, and `fsOut` is held at 0.
- R9: In frame-sync slave mode, with no sync edge, the counter wraps at the programmed frame length.
- R10: A change to the frame length, sync length, sync source or sync polarity takes effect only at the next frame start.
- R11: While `cfgClkDisable` is 1 there are no bit steps and `bitIndex` holds its value. Counting resumes from that value once it clears.
- R12: After reset, `bitIndex`, `frameStart`, `bitValid`, `bclkOut` and `fsOut` are 0 (with `cfgFsInvert` at 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgBclkSlave | input | 1 | 1: take bit clock from `bclkIn` |
| cfgBclkFallEdge | input | 1 | 1: step on falling bit-clock edge |
| cfgClkDisable | input | 1 | 1: stop bit clock and stepping |
| cfgHalfPeriod | input | DIV_W | Internal bit clock half period minus one, in system cycles |
| cfgFrameLenM1 | input | LEN_W | Frame length minus one, in bits |
| cfgSyncLen | input | LEN_W | Frame sync pulse length, in bits |
| cfgFsSlave | input | 1 | 1: follow external `fsIn` |
| cfgFsInvert | input | 1 | 1: frame begins on falling sync edge |
| bclkIn | input | 1 | External bit clock |
| fsIn | input | 1 | External frame sync |
| bclkOut | output | 1 | Generated bit clock |
| fsOut | output | 1 | Generated frame sync |
| bitIndex | output | LEN_W | Bit position within the frame |
| frameStart | output | 1 | High during bit 0 of a frame |
| bitValid | output | 1 | One-cycle pulse when `bitIndex` updates |

## Verification
Master runs are tried with random frame lengths, sync lengths, polarities, step edges and divider values. Directed cases cover a 50% I2S-style frame, a one-bit DSP pulse, a zero-length sync and the full 1024-bit frame. These runs separate errors in the counter wrap, in the sync comparison, in the polarity and in the bit-step spacing. A length change written mid-frame shows whether the old length is kept to the frame end. A disable window shows whether the counter freezes and then resumes from the same value. Slave runs feed an external bit clock and a sync pattern with idle bits before lock, a full frame, an early resync edge and a long stretch with no edge. The pattern runs in both polarities, which separates lock-on, restart and free-running wrap behaviour.

// File: rtl/pcm_ft_pkg.sv
package pcm_ft_pkg;

  // Per-cycle strobes passed from timing control to the frame datapath
  typedef struct packed {
    logic tick;      // selected bit-clock edge seen this cycle
    logic syncRise;  // sampled sync went 0->1 at this tick
    logic syncFall;  // sampled sync went 1->0 at this tick
  } ftStrobe_t;

  typedef enum logic {
    FT_IDLE = 1'b0,
    FT_RUN  = 1'b1
  } ftState_t;

endpackage

// File: rtl/pcm_ft_sync.sv
module pcm_ft_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pcm_ft_ctrl.sv
module pcm_ft_ctrl
  import pcm_ft_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgBclkSlave,
  input  logic             cfgBclkFallEdge,
  input  logic             cfgClkDisable,
  input  logic [DIV_W-1:0] cfgHalfPeriod,
  input  logic             bclkIn,
  input  logic             fsIn,
  output logic             bclkOut,
  output ftStrobe_t        strobe
);
  logic [DIV_W-1:0] divCnt;
  logic bclkGen;
  logic bclkSync, fsSync;
  logic lvl, prevLvl, riseB, fallB, tick;
  logic fsPrev;

  // Internal bit clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bclkGen <= 1'b0;
    end else if (cfgClkDisable || cfgBclkSlave) begin
      divCnt  <= '0;
      bclkGen <= 1'b0;
    end else if (divCnt >= cfgHalfPeriod) begin
      divCnt  <= '0;
      bclkGen <= ~bclkGen;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end

  // External pins enter through synchronizers
  for (genvar g = 0; g < 2; g++) begin : g_sync
    if (g == 0) begin : g_bclk
      pcm_ft_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rstN(rstN), .d(bclkIn), .q(bclkSync));
    end else begin : g_fs
      pcm_ft_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rstN(rstN), .d(fsIn), .q(fsSync));
    end
  end

  assign lvl = cfgBclkSlave ? bclkSync : bclkGen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= lvl;
  end

  assign riseB = lvl & ~prevLvl;
  assign fallB = ~lvl & prevLvl;
  assign tick  = !cfgClkDisable && (cfgBclkFallEdge ? fallB : riseB);

  // Sync sampled once per bit step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     fsPrev <= 1'b0;
    else if (tick) fsPrev <= fsSync;
  end

  assign strobe.tick     = tick;
  assign strobe.syncRise = tick & fsSync & ~fsPrev;
  assign strobe.syncFall = tick & ~fsSync & fsPrev;
  assign bclkOut         = bclkGen;

  AST_BCLK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClkDisable || cfgBclkSlave) |=> !bclkOut); // R4
  AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgClkDisable && !cfgBclkSlave && divCnt < cfgHalfPeriod)
      |=> (bclkOut == $past(bclkOut))); // R4
endmodule

// File: rtl/pcm_ft_dpath.sv
module pcm_ft_dpath
  import pcm_ft_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ftStrobe_t        strobe,
  input  logic [LEN_W-1:0] cfgFrameLenM1,
  input  logic [LEN_W-1:0] cfgSyncLen,
  input  logic             cfgFsSlave,
  input  logic             cfgFsInvert,
  output logic [LEN_W-1:0] bitIndex,
  output logic             frameStart,
  output logic             bitValid,
  output logic             fsOut
);
  ftState_t         state;
  logic [LEN_W-1:0] cnt, nextCnt;
  logic [LEN_W-1:0] actLenM1, actSync;
  logic             actFsSlave, actFsInv;
  logic             selSlave, selInv, syncHit, atEnd, startNow, stepNow;

  function automatic logic fsLevel(input logic [LEN_W-1:0] idx,
                                   input logic [LEN_W-1:0] len,
                                   input logic inv, input logic slave);
    return slave ? 1'b0 : ((idx < len) ^ inv);
  endfunction

  // Before the first frame the live fields decide how to start
  assign selSlave = (state == FT_RUN) ? actFsSlave : cfgFsSlave;
  assign selInv   = (state == FT_RUN) ? actFsInv   : cfgFsInvert;
  assign syncHit  = selSlave && (selInv ? strobe.syncFall : strobe.syncRise);
  assign atEnd    = (cnt == actLenM1);
  assign startNow = strobe.tick &&
                    ((state == FT_IDLE) ? (!cfgFsSlave || syncHit)
                                        : (atEnd || syncHit));
  assign stepNow  = strobe.tick && (state == FT_RUN) && !startNow;
  assign nextCnt  = cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= FT_IDLE;
      cnt        <= '0;
      actLenM1   <= '0;
      actSync    <= '0;
      actFsSlave <= 1'b0;
      actFsInv   <= 1'b0;
      frameStart <= 1'b0;
      bitValid   <= 1'b0;
      fsOut      <= 1'b0;
    end else begin
      bitValid <= startNow | stepNow;
      if (startNow) begin
        state      <= FT_RUN;
        cnt        <= '0;
        actLenM1   <= cfgFrameLenM1;
        actSync    <= cfgSyncLen;
        actFsSlave <= cfgFsSlave;
        actFsInv   <= cfgFsInvert;
        frameStart <= 1'b1;
        fsOut      <= fsLevel('0, cfgSyncLen, cfgFsInvert, cfgFsSlave);
      end else if (stepNow) begin
        cnt        <= nextCnt;
        frameStart <= 1'b0;
        fsOut      <= fsLevel(nextCnt, actSync, actFsInv, actFsSlave);
      end else if (state == FT_IDLE) begin
        fsOut      <= cfgFsSlave ? 1'b0 : cfgFsInvert;
      end
    end
  end

  assign bitIndex = cnt;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == FT_RUN) |-> (cnt <= actLenM1)); // R1
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !frameStart) |-> (bitIndex == $past(bitIndex) + 1'b1)); // R1
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (bitIndex == '0)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !startNow |=> ($stable(actLenM1) && $stable(actSync) && $stable(actFsInv))); // R10
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == FT_RUN && actFsSlave) |-> !fsOut); // R8
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_ft_pkg::*;
#(
  parameter int LEN_W       = 10,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgBclkSlave,
  input  logic             cfgBclkFallEdge,
  input  logic             cfgClkDisable,
  input  logic [DIV_W-1:0] cfgHalfPeriod,
  input  logic [LEN_W-1:0] cfgFrameLenM1,
  input  logic [LEN_W-1:0] cfgSyncLen,
  input  logic             cfgFsSlave,
  input  logic             cfgFsInvert,
  input  logic             bclkIn,
  input  logic             fsIn,
  output logic             bclkOut,
  output logic             fsOut,
  output logic [LEN_W-1:0] bitIndex,
  output logic             frameStart,
  output logic             bitValid
);
  ftStrobe_t strobe;

  pcm_ft_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgBclkSlave(cfgBclkSlave), .cfgBclkFallEdge(cfgBclkFallEdge),
    .cfgClkDisable(cfgClkDisable), .cfgHalfPeriod(cfgHalfPeriod),
    .bclkIn(bclkIn), .fsIn(fsIn),
    .bclkOut(bclkOut), .strobe(strobe));

  pcm_ft_dpath #(.LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgFrameLenM1(cfgFrameLenM1), .cfgSyncLen(cfgSyncLen),
    .cfgFsSlave(cfgFsSlave), .cfgFsInvert(cfgFsInvert),
    .bitIndex(bitIndex), .frameStart(frameStart),
    .bitValid(bitValid), .fsOut(fsOut));
endmodule

// File: tb/pcm_frame_timer_tb.sv
`timescale 1ns/1ps
module pcm_frame_timer_tb;
  localparam int LEN_W = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgBclkSlave = 1'b0, cfgBclkFallEdge = 1'b0, cfgClkDisable = 1'b0;
  logic [DIV_W-1:0] cfgHalfPeriod = '0;
  logic [LEN_W-1:0] cfgFrameLenM1 = '0, cfgSyncLen = '0;
  logic cfgFsSlave = 1'b0, cfgFsInvert = 1'b0;
  logic bclkIn = 1'b0, fsIn = 1'b0;
  logic bclkOut, fsOut, frameStart, bitValid;
  logic [LEN_W-1:0] bitIndex;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  pcm_frame_timer #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgBclkSlave(cfgBclkSlave), .cfgBclkFallEdge(cfgBclkFallEdge),
    .cfgClkDisable(cfgClkDisable), .cfgHalfPeriod(cfgHalfPeriod),
    .cfgFrameLenM1(cfgFrameLenM1), .cfgSyncLen(cfgSyncLen),
    .cfgFsSlave(cfgFsSlave), .cfgFsInvert(cfgFsInvert),
    .bclkIn(bclkIn), .fsIn(fsIn),
    .bclkOut(bclkOut), .fsOut(fsOut), .bitIndex(bitIndex),
    .frameStart(frameStart), .bitValid(bitValid));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic checkEq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expFs(int idx, int sync, bit inv);
    return ((idx < sync) ? 1 : 0) ^ int'(inv);
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitValid(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!bitValid && gap < 20000);
    if (!bitValid) checkEq("R1", "bitValid timeout", 0, 1);
  endtask

  task automatic runMaster(int lenM1, int sync, bit inv, bit fallEdge, int half,
                           int frames, int changeAt, int newLenM1);
    int expIdx = 0;
    int curLen = lenM1;
    int done = 0;
    int b = 0;
    int gap;
    cfgBclkSlave = 0; cfgClkDisable = 0; cfgFsSlave = 0;
    cfgFrameLenM1 = LEN_W'(lenM1); cfgSyncLen = LEN_W'(sync);
    cfgFsInvert = inv; cfgBclkFallEdge = fallEdge; cfgHalfPeriod = DIV_W'(half);
    doReset();
    while (done < frames) begin
      waitValid(gap);
      checkEq("R1", "bitIndex", int'(bitIndex), expIdx);
      checkEq("R7", "frameStart", int'(frameStart), (expIdx == 0) ? 1 : 0);
      checkEq(inv ? "R3" : "R2", "fsOut", int'(fsOut), expFs(expIdx, sync, inv));
      if (b > 0) checkEq("R4", "step spacing", gap, 2 * (half + 1));
      if (half > 0) checkEq("R5", "bclk level at step", int'(bclkOut), fallEdge ? 0 : 1);
      if (b == changeAt) cfgFrameLenM1 = LEN_W'(newLenM1);
      if (expIdx == curLen) begin
        expIdx = 0;
        done++;
        if (changeAt >= 0 && b >= changeAt) curLen = newLenM1;
      end else begin
        expIdx++;
      end
      b++;
    end
  endtask

  task automatic slaveBit(bit lvl);
    @(negedge clk);
    fsIn = lvl;
    bclkIn = 1'b0;
    repeat (4) @(negedge clk);
    bclkIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic runSlave(bit inv);
    int pat[29] = '{0,0,0, 1,1,1,1,0,0,0,0, 1,1,1,1,0, 1,
                    0,0,0,0,0,0,0,0,0,0,0,0};
    bit running = 0;
    int expIdx = 0;
    bit prevFs = 0;
    cfgBclkSlave = 1; cfgClkDisable = 0; cfgBclkFallEdge = 0;
    cfgFsSlave = 1; cfgFsInvert = inv;
    cfgFrameLenM1 = 10'd7; cfgSyncLen = 10'd3;
    bclkIn = 0; fsIn = inv;
    doReset();
    foreach (pat[i]) begin
      bit cur = pat[i][0] ^ inv;
      bit edgeHit = inv ? (prevFs && !cur) : (!prevFs && cur);
      string tag;
      slaveBit(cur);
      if (!running) begin
        tag = "R8";
        if (edgeHit) begin running = 1; expIdx = 0; end
      end else if (edgeHit) begin
        tag = "R8"; expIdx = 0;
      end else if (expIdx == 7) begin
        tag = "R9"; expIdx = 0;
      end else begin
        tag = "R6"; expIdx++;
      end
      prevFs = cur;
      checkEq(tag, "slave bitIndex", int'(bitIndex), expIdx);
      checkEq(tag, "slave frameStart", int'(frameStart), (running && expIdx == 0) ? 1 : 0);
      checkEq("R8", "slave fsOut", int'(fsOut), 0);
    end
  endtask

  initial begin
    int seedDummy;
    int gap;
    int held;
    seedDummy = $urandom(32'd7531);

    // R12: reset state
    cfgHalfPeriod = 8'd3; cfgFrameLenM1 = 10'd7; cfgSyncLen = 10'd2;
    doReset();
    checkEq("R12", "bitIndex", int'(bitIndex), 0);
    checkEq("R12", "frameStart", int'(frameStart), 0);
    checkEq("R12", "bitValid", int'(bitValid), 0);
    checkEq("R12", "bclkOut", int'(bclkOut), 0);
    checkEq("R12", "fsOut", int'(fsOut), 0);

    // Directed master cases
    runMaster(31, 16, 1, 0, 1, 2, -1, 0);    // I2S-style 50% sync
    runMaster(7, 1, 0, 0, 0, 3, -1, 0);      // one-bit DSP pulse
    runMaster(3, 0, 0, 1, 2, 2, -1, 0);      // zero-length sync, falling edge
    runMaster(1023, 512, 1, 0, 0, 2, -1, 0); // full 1024-bit frame
    // R10: length change mid-frame applies at next frame
    runMaster(7, 2, 0, 0, 1, 3, 2, 3);

    // Random master cases
    for (int k = 0; k < 8; k++) begin
      int lenM1 = 1 + int'($urandom % 20);
      int sync  = int'($urandom % (lenM1 + 3));
      bit inv   = bit'($urandom % 2);
      bit fe    = bit'($urandom % 2);
      int half  = int'($urandom % 4);
      runMaster(lenM1, sync, inv, fe, half, 2, -1, 0);
    end

    // R11: clock disable freezes the counter
    runMaster(7, 2, 0, 0, 2, 1, -1, 0);
    repeat (2) waitValid(gap);
    @(negedge clk);
    cfgClkDisable = 1;
    @(negedge clk);
    held = int'(bitIndex);
    begin
      int seen = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (bitValid) seen++;
      end
      checkEq("R11", "steps while disabled", seen, 0);
    end
    checkEq("R11", "bitIndex held", int'(bitIndex), held);
    checkEq("R4", "bclkOut while disabled", int'(bclkOut), 0);
    cfgClkDisable = 0;
    waitValid(gap);
    checkEq("R11", "bitIndex after resume", int'(bitIndex), (held == 7) ? 0 : held + 1);

    // Slave frame sync, both polarities
    runSlave(0);
    runSlave(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule